// File: doc/BRIEF.md
# Floating-Point Register Stack Unit

This block holds eight 80-bit extended-precision registers organised as a circular stack. A 3-bit top pointer names the register currently seen as ST(0). Register ST(i) is the physical entry at (top + i) modulo 8. A one-bit tag per entry records whether the entry holds a value. Each push moves the top pointer down by one and writes the new ST(0).

A push takes its operand from one of three places:
- the 80-bit data input;
- a copy of a stack-relative register ST(i);
- one of seven built-in constants, chosen by a 3-bit selector.

Each constant is stored already rounded for each of the four rounding modes, so the unit has no rounder. A 2-bit rounding-control input picks which stored value is used.

If the destination entry already holds a value, the push overflows. The unit then reports the overflow through the C1 flag and a one-cycle stack-fault pulse, and loads the destination with the indefinite NaN instead of the operand. Format conversion, arithmetic and memory access belong to other blocks, which drive this unit's push inputs.

Top module: `fpstk_unit`

## Requirements
- R1: On a clock edge with `push_valid` high, `top_ptr` becomes the old value minus one, modulo 8, and `st0_value` shows the pushed operand from that edge on.
- R2: With `push_src` = 2'b00, the pushed operand is `push_data` unchanged in all 80 bits.
- R3: With `push_src` = 2'b01, the operand is ST(`src_index`), read relative to the top pointer before the decrement. Pushing ST(0) therefore duplicates the top of stack.
- R4: A push overflows when the destination entry (old top minus one) is tagged as holding a value. On an overflowing push:
  - `c1_flag` becomes 1;
  - `stack_fault` is 1 for exactly the following cycle;
  - the destination is loaded with the indefinite NaN 80'hFFFF_C000_0000_0000_0000 (sign 1, exponent 7FFF, significand bits 63 and 62 set, all others 0);
  - `top_ptr` still decrements.
- R5: A push that does not overflow clears `c1_flag` to 0, and `stack_fault` stays 0.
- R6: With `push_src` = 2'b10 or 2'b11, `const_sel` picks a constant:

  | `const_sel` | Constant |
  |---|---|
  | 0 | +1.0 |
  | 1 | log2(10) |
  | 2 | log2(e) |
  | 3 | pi |
  | 4 | log10(2) |
  | 5 | ln(2) |
  | 6 | +0.0 |
  | 7 | +0.0 |

- R7: `round_ctl` encodes the rounding mode: 00 to nearest, 01 downward, 10 upward, 11 toward zero. Each constant is its 66-bit value rounded to a 64-bit significand in that mode:
  - downward and toward zero truncate;
  - upward adds one unit in the last place whenever the discarded bits are nonzero;
  - to nearest gives the legacy coprocessor values.
  - +1.0 and +0.0 are the same in every mode.
- R8: Rounding a constant never sets `c1_flag`, including when the constant was rounded up. `c1_flag` reflects only overflow.
- R9: In a cycle without `push_valid`, `top_ptr`, `st0_value` and `c1_flag` hold their values and `stack_fault` is 0.
- R10: An asynchronous active-low reset sets `top_ptr` to 0, empties all eight tags and clears `c1_flag` and `stack_fault`. After reset, eight pushes succeed and the ninth overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Perform a push on this edge |
| push_src | input | 2 | Operand source: 00 data input, 01 register, 1x constant |
| push_data | input | 80 | Operand for data-input pushes |
| src_index | input | 3 | Stack-relative index i for register pushes |
| const_sel | input | 3 | Constant selector |
| round_ctl | input | 2 | Rounding mode for constants |
| c1_flag | output | 1 | Condition flag C1, set by an overflowing push |
| stack_fault | output | 1 | One-cycle pulse after an overflowing push |
| st0_value | output | 80 | Current contents of ST(0) |
| top_ptr | output | 3 | Physical index of ST(0) |

## Verification
The assertions assume that a register push never names an empty entry. Copying an empty register would be a stack underflow, and this unit does not define it. The stimulus respects this: before each register push it fills at most seven entries and only asks for indices within the filled range. Overflow is exercised only by pushing onto a full stack, never by copying. Reset is always applied between scenarios, so every expected value starts from an empty stack with the top pointer at 0.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

  localparam int unsigned EXT_W = 80;
  localparam int unsigned CSEL_W = 3;

  typedef enum logic [1:0] {
    SRC_PORT  = 2'b00,
    SRC_REG   = 2'b01,
    SRC_CONST = 2'b10,
    SRC_CALT  = 2'b11
  } push_src_e;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } rnd_mode_e;

  // Default quiet NaN written on overflow
  localparam logic [EXT_W-1:0] INDEF_NAN = 80'hFFFF_C000_0000_0000_0000;

  // Stored constant: truncated value, value one ulp above, and the
  // choice used in round-to-nearest
  typedef struct packed {
    logic [EXT_W-1:0] lo;
    logic [EXT_W-1:0] hi;
    logic             near_hi;
  } const_pair_t;

  function automatic const_pair_t const_pair(input logic [CSEL_W-1:0] sel);
    const_pair_t p;
    case (sel)
      3'd0: begin
        p.lo = 80'h3FFF_8000_0000_0000_0000;
        p.hi = 80'h3FFF_8000_0000_0000_0000;
        p.near_hi = 1'b0;
      end
      3'd1: begin
        p.lo = 80'h4000_D49A_784B_CD1B_8AFE;
        p.hi = 80'h4000_D49A_784B_CD1B_8AFF;
        p.near_hi = 1'b0;
      end
      3'd2: begin
        p.lo = 80'h3FFF_B8AA_3B29_5C17_F0BB;
        p.hi = 80'h3FFF_B8AA_3B29_5C17_F0BC;
        p.near_hi = 1'b1;
      end
      3'd3: begin
        p.lo = 80'h4000_C90F_DAA2_2168_C234;
        p.hi = 80'h4000_C90F_DAA2_2168_C235;
        p.near_hi = 1'b1;
      end
      3'd4: begin
        p.lo = 80'h3FFD_9A20_9A84_FBCF_F798;
        p.hi = 80'h3FFD_9A20_9A84_FBCF_F799;
        p.near_hi = 1'b1;
      end
      3'd5: begin
        p.lo = 80'h3FFE_B172_17F7_D1CF_79AB;
        p.hi = 80'h3FFE_B172_17F7_D1CF_79AC;
        p.near_hi = 1'b1;
      end
      default: begin
        p.lo = '0;
        p.hi = '0;
        p.near_hi = 1'b0;
      end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/fpstk_const_rom.sv
module fpstk_const_rom
  import fpstk_pkg::*;
(
  input  logic [CSEL_W-1:0] sel_i,
  input  logic [1:0]        rnd_i,
  output logic [EXT_W-1:0]  value_o
);

  localparam int unsigned NCONST = 1 << CSEL_W;

  logic [EXT_W-1:0] tbl_near [NCONST];
  logic [EXT_W-1:0] tbl_down [NCONST];
  logic [EXT_W-1:0] tbl_up   [NCONST];

  // One pre-rounded entry per selector and mode
  for (genvar g = 0; g < NCONST; g++) begin : g_const
    localparam const_pair_t PAIR = const_pair(CSEL_W'(g));
    assign tbl_down[g] = PAIR.lo;
    assign tbl_up[g]   = PAIR.hi;
    assign tbl_near[g] = PAIR.near_hi ? PAIR.hi : PAIR.lo;
  end

  always_comb begin
    unique case (rnd_mode_e'(rnd_i))
      RND_NEAR: value_o = tbl_near[sel_i];
      RND_UP:   value_o = tbl_up[sel_i];
      default:  value_o = tbl_down[sel_i];
    endcase
  end

endmodule

// File: rtl/fpstk_regfile.sv
module fpstk_regfile #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 80,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [AW-1:0]    rd_a_addr_i,
  output logic [WIDTH-1:0] rd_a_data_o,
  input  logic [AW-1:0]    rd_b_addr_i,
  output logic [WIDTH-1:0] rd_b_data_o
);

  logic [WIDTH-1:0] entry_q [DEPTH];

  // Datapath storage carries no reset; validity lives in the tags
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic entry_en;
    assign entry_en = wr_en_i && (wr_addr_i == AW'(e));
    always_ff @(posedge clk) begin
      if (entry_en) begin
        entry_q[e] <= wr_data_i;
      end
    end
  end

  assign rd_a_data_o = entry_q[rd_a_addr_i];
  assign rd_b_data_o = entry_q[rd_b_addr_i];

endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  output logic [AW-1:0] top_o,
  output logic [AW-1:0] dest_o,
  output logic          ovf_o,
  output logic          c1_o,
  output logic          fault_o
);

  logic [AW-1:0]    top_q, top_d;
  logic [DEPTH-1:0] tag_q, tag_d;
  logic             c1_q, c1_d;
  logic             fault_q, fault_d;
  logic [AW-1:0]    dest;
  logic             ovf;

  assign dest = top_q - AW'(1);
  assign ovf  = tag_q[dest];

  always_comb begin
    top_d   = top_q;
    tag_d   = tag_q;
    c1_d    = c1_q;
    fault_d = 1'b0;
    if (push_i) begin
      top_d       = dest;
      tag_d[dest] = 1'b1;
      c1_d        = ovf;
      fault_d     = ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q   <= '0;
      tag_q   <= '0;
      c1_q    <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      top_q   <= top_d;
      tag_q   <= tag_d;
      c1_q    <= c1_d;
      fault_q <= fault_d;
    end
  end

  assign top_o   = top_q;
  assign dest_o  = dest;
  assign ovf_o   = ovf;
  assign c1_o    = c1_q;
  assign fault_o = fault_q;

  // R1
  top_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> top_q == $past(top_q) - AW'(1));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push_i |=> $stable(top_q) && $stable(c1_q) && !fault_q);

  // R4
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && ovf |=> c1_q && fault_q);

  // R5
  clean_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && !ovf |=> !c1_q && !fault_q);

  // R10
  tag_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tag_q) >= $past($countones(tag_q)));

endmodule

// File: rtl/fpstk_unit.sv
module fpstk_unit
  import fpstk_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [1:0]        push_src,
  input  logic [EXT_W-1:0]  push_data,
  input  logic [AW-1:0]     src_index,
  input  logic [CSEL_W-1:0] const_sel,
  input  logic [1:0]        round_ctl,
  output logic              c1_flag,
  output logic              stack_fault,
  output logic [EXT_W-1:0]  st0_value,
  output logic [AW-1:0]     top_ptr
);

  logic [AW-1:0]    top;
  logic [AW-1:0]    dest;
  logic             ovf;
  logic [AW-1:0]    src_phys;
  logic [EXT_W-1:0] src_value;
  logic [EXT_W-1:0] const_value;
  logic [EXT_W-1:0] operand;
  logic [EXT_W-1:0] wr_data;

  fpstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_valid),
    .top_o   (top),
    .dest_o  (dest),
    .ovf_o   (ovf),
    .c1_o    (c1_flag),
    .fault_o (stack_fault)
  );

  fpstk_const_rom u_rom (
    .sel_i   (const_sel),
    .rnd_i   (round_ctl),
    .value_o (const_value)
  );

  // ST(i) is taken relative to the pointer before it moves
  assign src_phys = top + src_index;

  always_comb begin
    unique case (push_src_e'(push_src))
      SRC_PORT: operand = push_data;
      SRC_REG:  operand = src_value;
      default:  operand = const_value;
    endcase
  end

  assign wr_data = ovf ? INDEF_NAN : operand;

  fpstk_regfile #(.DEPTH(DEPTH), .WIDTH(EXT_W)) u_regs (
    .clk         (clk),
    .wr_en_i     (push_valid),
    .wr_addr_i   (dest),
    .wr_data_i   (wr_data),
    .rd_a_addr_i (src_phys),
    .rd_a_data_o (src_value),
    .rd_b_addr_i (top),
    .rd_b_data_o (st0_value)
  );

  assign top_ptr = top;

  // R1
  st0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |=> st0_value == $past(wr_data));

  // R4
  ovf_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && ovf |=> st0_value == INDEF_NAN);

  // R2
  port_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !ovf && push_src == 2'b00 |=> st0_value == $past(push_data));

  // R9
  st0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push_valid |=> $stable(st0_value));

endmodule

// File: tb/fpstk_unit_bench.sv
`timescale 1ns/1ps
module fpstk_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        push_valid;
  logic [1:0]  push_src;
  logic [79:0] push_data;
  logic [2:0]  src_index;
  logic [2:0]  const_sel;
  logic [1:0]  round_ctl;
  logic        c1_flag;
  logic        stack_fault;
  logic [79:0] st0_value;
  logic [2:0]  top_ptr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [79:0] NAN_EXP = 80'hFFFF_C000_0000_0000_0000;

  always #2.5 clk = ~clk;

  fpstk_unit u_fpstk_unit (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_src(push_src),
    .push_data(push_data), .src_index(src_index), .const_sel(const_sel),
    .round_ctl(round_ctl), .c1_flag(c1_flag), .stack_fault(stack_fault),
    .st0_value(st0_value), .top_ptr(top_ptr)
  );

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected constant: 64-bit truncated significand plus two further bits,
  // rounded here according to the mode
  function automatic logic [79:0] exp_const(input int sel, input int rm);
    logic [15:0] ex;
    logic [63:0] tr;
    logic [1:0]  gb;
    logic        up;
    case (sel)
      0: begin ex = 16'h3FFF; tr = 64'h8000_0000_0000_0000; gb = 2'b00; end
      1: begin ex = 16'h4000; tr = 64'hD49A_784B_CD1B_8AFE; gb = 2'b01; end
      2: begin ex = 16'h3FFF; tr = 64'hB8AA_3B29_5C17_F0BB; gb = 2'b10; end
      3: begin ex = 16'h4000; tr = 64'hC90F_DAA2_2168_C234; gb = 2'b11; end
      4: begin ex = 16'h3FFD; tr = 64'h9A20_9A84_FBCF_F798; gb = 2'b10; end
      5: begin ex = 16'h3FFE; tr = 64'hB172_17F7_D1CF_79AB; gb = 2'b11; end
      default: begin ex = 16'h0; tr = 64'h0; gb = 2'b00; end
    endcase
    case (rm)
      0: up = (gb >= 2'b10);
      2: up = (gb != 2'b00);
      default: up = 1'b0;
    endcase
    return {ex, tr + {63'd0, up}};
  endfunction

  function automatic logic [79:0] dval(input int k);
    return {16'h3F00 + 16'(k), 64'h8000_0000_0000_1000 + 64'(k) * 64'h1111};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_push(input logic [1:0] src, input logic [79:0] d,
                         input logic [2:0] idx, input logic [2:0] sel,
                         input logic [1:0] rm);
    @(negedge clk);
    push_valid = 1'b1;
    push_src   = src;
    push_data  = d;
    src_index  = idx;
    const_sel  = sel;
    round_ctl  = rm;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    push_valid = 1'b0;
    push_src = 2'b00;
    push_data = '0;
    src_index = '0;
    const_sel = '0;
    round_ctl = '0;

    // R10: reset state and fill sequence
    do_reset();
    chk("R10 top", 80'(top_ptr), 80'd0);
    chk("R10 c1", 80'(c1_flag), 80'd0);
    chk("R10 fault", 80'(stack_fault), 80'd0);
    for (int k = 1; k <= 8; k++) begin
      do_push(2'b00, dval(k), 3'd0, 3'd0, 2'b00);
      chk("R1 top", 80'(top_ptr), 80'((8 - k) % 8));
      chk("R2 st0", st0_value, dval(k));
      chk("R5 c1", 80'(c1_flag), 80'd0);
      chk("R5 fault", 80'(stack_fault), 80'd0);
    end
    // R4: ninth push overflows
    do_push(2'b00, dval(9), 3'd0, 3'd0, 2'b00);
    chk("R4 top", 80'(top_ptr), 80'd7);
    chk("R4 st0", st0_value, NAN_EXP);
    chk("R4 c1", 80'(c1_flag), 80'd1);
    chk("R4 fault", 80'(stack_fault), 80'd1);
    // R9: idle cycle
    @(negedge clk);
    chk("R9 fault", 80'(stack_fault), 80'd0);
    chk("R9 c1", 80'(c1_flag), 80'd1);
    chk("R9 top", 80'(top_ptr), 80'd7);
    chk("R9 st0", st0_value, NAN_EXP);
    // R4: constant push onto full stack also overflows
    do_push(2'b10, '0, 3'd0, 3'd3, 2'b10);
    chk("R4 const st0", st0_value, NAN_EXP);
    chk("R4 const fault", 80'(stack_fault), 80'd1);

    // R3: register pushes over each filled index
    for (int i = 0; i < 7; i++) begin
      do_reset();
      for (int k = 0; k < 7; k++) do_push(2'b00, dval(k + 20), 3'd0, 3'd0, 2'b00);
      do_push(2'b01, '0, 3'(i), 3'd0, 2'b00);
      chk("R3 st0", st0_value, dval(26 - i));
      chk("R3 top", 80'(top_ptr), 80'd0);
      chk("R5 c1 reg", 80'(c1_flag), 80'd0);
    end

    // R6/R7/R8: every selector in every rounding mode
    for (int rm = 0; rm < 4; rm++) begin
      for (int s = 0; s < 8; s++) begin
        do_reset();
        do_push((s % 2 == 0) ? 2'b10 : 2'b11, '1, 3'd0, 3'(s), 2'(rm));
        chk($sformatf("R6 R7 sel%0d mode%0d", s, rm), st0_value, exp_const(s, rm));
        chk("R8 c1", 80'(c1_flag), 80'd0);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule